// File: doc/BRIEF.md
# Bus Parity Checker and Error Reporter for a Target Device

This block watches the shared 32-bit address/data bus of a parallel PCI target and checks even parity over the address/data lines and the byte-enable lines. The parity bit arrives one clock after the phase it protects. The block checks every address phase on the bus. It checks only those data phases in which this device is the target. It reports each error in three places: two sticky status bits, the active-low data parity error pin, and the active-low system error pin.

The block takes four kinds of input. Bus tracking logic tells it which clocks carry an address phase or a transferred target data phase. The address decoder tells it whether an address selects this device. The command register supplies the two reporting enables. The configuration write path clears the status bits by writing ones to them. The block returns a claim flag to the termination logic. That flag does not depend on parity, so a faulty address that still decodes to the device is handled as a normal access. No parity error of any kind requests early termination of the cycle.

Top module: `pci_parity_monitor`

## Requirements
- R1: The expected parity bit is the XOR of AD[31:0] and C/BE#[3:0]. Any bit that makes the 37-bit total even is correct. A correct parity bit changes no status bit and asserts no error pin.
- R2: A data phase marked as a transferred target phase that is followed by a wrong parity bit sets status bit 15 (detected parity error). The bit shows as 1 two clocks after that data phase.
- R3: For a data parity error, PERR# goes low two clocks after the data phase only when the parity error response enable is 1. It stays low for one clock per erroneous data phase, so back-to-back bad phases keep it low for back-to-back clocks.
- R4: An address phase with wrong parity sets status bit 15 whether or not the address decodes to this device, and whatever the two enables are.
- R5: For an address parity error with either enable at 0, SERR# stays high and status bit 14 (signaled system error) stays 0.
- R6: For an address parity error with both enables at 1, status bits 14 and 15 read 1 two clocks after the address phase, and SERR# is low for exactly that one clock.
- R7: claim_o is 1 in the clock after an address phase exactly when the decoder reported a hit, whether the parity was good or bad. No parity error produces any termination request.
- R8: Status bits are sticky. A status write clears bit 15 where cfg_w1c_i[1] is 1 and clears bit 14 where cfg_w1c_i[0] is 1. A zero written leaves the bit unchanged. A new error in the same clock wins over the clear.
- R9: After reset, PERR# and SERR# are high, both status bits are 0, and claim_o is 0.
- R10: A clock with a wrong parity bit after a data phase that is not marked as a target transfer changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data lines |
| cbe_n_i | input | 4 | Command/byte-enable lines |
| par_i | input | 1 | Parity line, valid one clock after the phase it covers |
| addr_phase_i | input | 1 | This clock is an address phase |
| data_xfer_i | input | 1 | This clock transfers a data phase with this device as target |
| addr_hit_i | input | 1 | The decoder selects this device for the current address |
| cmd_perr_en_i | input | 1 | Command register parity error response enable (bit 6) |
| cmd_serr_en_i | input | 1 | Command register system error enable |
| cfg_sts_we_i | input | 1 | Configuration write to the status register |
| cfg_w1c_i | input | 2 | Written status bits 15 and 14, in that order |
| perr_n_o | output | 1 | Data parity error pin, active low |
| serr_n_o | output | 1 | System error pin, active low |
| sts_dpe_o | output | 1 | Status bit 15, detected parity error |
| sts_sse_o | output | 1 | Status bit 14, signaled system error |
| claim_o | output | 1 | Claim flag for the termination logic |

## Verification
The embedded assertions check four rules on every clock. A low PERR# or SERR# must be backed by its enable one clock earlier. Each pin must be mirrored in the matching status bit. A status bit may fall only after a write of one to it. A claim must trace back to a decoded address phase. Only the bench's scenarios can show the parity rule itself and the two-clock timing. They also show the split between an address and a data error, and that an address error is reported when the address misses. The last of these are the single-clock SERR# pulse and the set-over-clear priority.

// File: rtl/pci_parity_monitor.sv
module pci_parity_monitor #(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_i,
  input  logic [AD_W/8-1:0] cbe_n_i,
  input  logic            par_i,
  input  logic            addr_phase_i,
  input  logic            data_xfer_i,
  input  logic            addr_hit_i,
  input  logic            cmd_perr_en_i,
  input  logic            cmd_serr_en_i,
  input  logic            cfg_sts_we_i,
  input  logic [1:0]      cfg_w1c_i,
  output logic            perr_n_o,
  output logic            serr_n_o,
  output logic            sts_dpe_o,
  output logic            sts_sse_o,
  output logic            claim_o
);
  localparam int BE_W = AD_W / 8;

  logic [AD_W-1:0] ad_q;
  logic [BE_W-1:0] be_q;
  logic            addr_q, data_q, hit_q;
  logic            perr_q, serr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q   <= '0;
      be_q   <= '0;
      addr_q <= 1'b0;
      data_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      ad_q   <= ad_i;
      be_q   <= cbe_n_i;
      addr_q <= addr_phase_i;
      data_q <= data_xfer_i;
      hit_q  <= addr_phase_i & addr_hit_i;
    end
  end

  logic mismatch, addr_err, data_err, sys_err, clr_dpe, clr_sse;
  assign mismatch = (^{ad_q, be_q}) ^ par_i;
  assign addr_err = addr_q & mismatch;
  assign data_err = data_q & mismatch;
  assign sys_err  = addr_err & cmd_perr_en_i & cmd_serr_en_i;
  assign clr_dpe  = cfg_sts_we_i & cfg_w1c_i[1];
  assign clr_sse  = cfg_sts_we_i & cfg_w1c_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q    <= 1'b0;
      serr_q    <= 1'b0;
      sts_dpe_o <= 1'b0;
      sts_sse_o <= 1'b0;
    end else begin
      perr_q <= data_err & cmd_perr_en_i;
      serr_q <= sys_err;
      if (addr_err | data_err) sts_dpe_o <= 1'b1;
      else if (clr_dpe)        sts_dpe_o <= 1'b0;
      if (sys_err)             sts_sse_o <= 1'b1;
      else if (clr_sse)        sts_sse_o <= 1'b0;
    end
  end

  assign perr_n_o = ~perr_q;
  assign serr_n_o = ~serr_q;
  assign claim_o  = hit_q;

  a_r3_perr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(cmd_perr_en_i));
  a_r2_perr_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> sts_dpe_o);
  a_r5_serr_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> $past(cmd_perr_en_i && cmd_serr_en_i));
  a_r6_serr_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> (sts_sse_o && sts_dpe_o));
  a_r8_dpe_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_dpe_o) |-> $past(cfg_sts_we_i && cfg_w1c_i[1]));
  a_r8_sse_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_sse_o) |-> $past(cfg_sts_we_i && cfg_w1c_i[0]));
  a_r7_claim_from_decode: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o |-> $past(addr_phase_i && addr_hit_i));
endmodule

// File: tb/pci_parity_monitor_tb.sv
module pci_parity_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic par = 1'b0, addr_ph = 1'b0, dxfer = 1'b0, hit = 1'b0;
  logic per = 1'b0, sen = 1'b0, we = 1'b0;
  logic [1:0] w1c = '0;
  logic perr_n, serr_n, dpe, sse, claim;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_parity_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe), .par_i(par),
    .addr_phase_i(addr_ph), .data_xfer_i(dxfer), .addr_hit_i(hit),
    .cmd_perr_en_i(per), .cmd_serr_en_i(sen), .cfg_sts_we_i(we),
    .cfg_w1c_i(w1c), .perr_n_o(perr_n), .serr_n_o(serr_n),
    .sts_dpe_o(dpe), .sts_sse_o(sse), .claim_o(claim));

  typedef struct packed {
    logic [31:0] ad; logic [3:0] cbe; logic flip; logic is_addr; logic hit;
    logic per; logic sen; logic e_perr; logic e_serr; logic e_dpe; logic e_sse;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h1234_5678, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'hDEAD_BEEF, 4'h3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'h0000_0001, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h8000_1000, 4'h6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{32'h4000_2000, 4'h7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{32'hA5A5_5A5A, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'hFFFF_0000, 4'hB, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'h0F0F_0F0F, 4'h6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_status();
    @(negedge clk); we = 1'b1; w1c = 2'b11;
    @(negedge clk); we = 1'b0; w1c = 2'b00;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    ad = v.ad; cbe = v.cbe; addr_ph = v.is_addr; dxfer = ~v.is_addr;
    hit = v.hit; per = v.per; sen = v.sen;
    @(negedge clk);
    par = (^{v.ad, v.cbe}) ^ v.flip;
    addr_ph = 1'b0; dxfer = 1'b0; hit = 1'b0; ad = '0; cbe = '0;
    chk("R7 claim", claim, v.is_addr & v.hit);
    @(negedge clk);
    par = 1'b0;
    chk("R3 perr_n", perr_n, ~v.e_perr);
    chk("R5/R6 serr_n", serr_n, ~v.e_serr);
    chk("R1/R2/R4 dpe", dpe, v.e_dpe);
    chk("R5/R6 sse", sse, v.e_sse);
    @(negedge clk);
    chk("R3 perr_n release", perr_n, 1'b1);
    chk("R6 serr_n one clock", serr_n, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 perr_n reset", perr_n, 1'b1);
    chk("R9 serr_n reset", serr_n, 1'b1);
    chk("R9 dpe reset", dpe, 1'b0);
    chk("R9 sse reset", sse, 1'b0);
    chk("R9 claim reset", claim, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      run_vec(VECS[i]);
      clear_status();
      chk("R8 w1c dpe", dpe, 1'b0);
      chk("R8 w1c sse", sse, 1'b0);
    end

    // R3: two back-to-back bad data phases
    per = 1'b1; sen = 1'b0;
    @(negedge clk); ad = 32'h1111_0000; cbe = 4'h0; dxfer = 1'b1;
    @(negedge clk); par = ~(^{32'h1111_0000, 4'h0}); ad = 32'h0000_0007; cbe = 4'h1;
    @(negedge clk); par = ~(^{32'h0000_0007, 4'h1}); dxfer = 1'b0; ad = '0; cbe = '0;
    chk("R3 perr back-to-back 1", perr_n, 1'b0);
    @(negedge clk); par = 1'b0;
    chk("R3 perr back-to-back 2", perr_n, 1'b0);
    @(negedge clk);
    chk("R3 perr after burst", perr_n, 1'b1);
    clear_status();

    // R10: data phase not for this target, bad parity
    @(negedge clk); ad = 32'hCAFE_0001; cbe = 4'h0; dxfer = 1'b0;
    @(negedge clk); par = ~(^{32'hCAFE_0001, 4'h0}); ad = '0;
    @(negedge clk); par = 1'b0;
    chk("R10 perr_n", perr_n, 1'b1);
    chk("R10 dpe", dpe, 1'b0);

    // R8 stickiness and selective clear
    per = 1'b1; sen = 1'b1;
    run_vec('{32'h8000_0004, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1});
    repeat (5) @(negedge clk);
    chk("R8 dpe sticky", dpe, 1'b1);
    chk("R8 sse sticky", sse, 1'b1);
    @(negedge clk); we = 1'b1; w1c = 2'b00;
    @(negedge clk); we = 1'b0;
    chk("R8 zero write dpe", dpe, 1'b1);
    chk("R8 zero write sse", sse, 1'b1);
    @(negedge clk); we = 1'b1; w1c = 2'b01;
    @(negedge clk); we = 1'b0; w1c = 2'b00;
    chk("R8 clear sse only", sse, 1'b0);
    chk("R8 dpe kept", dpe, 1'b1);
    clear_status();

    // R8 set wins over simultaneous clear
    @(negedge clk); ad = 32'h0000_00F0; cbe = 4'h0; dxfer = 1'b1;
    @(negedge clk); par = ~(^{32'h0000_00F0, 4'h0}); dxfer = 1'b0; ad = '0;
    we = 1'b1; w1c = 2'b11;
    @(negedge clk); par = 1'b0; we = 1'b0; w1c = 2'b00;
    chk("R8 set beats clear", dpe, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule